// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one indivisible read-modify-write on a single byte of data memory. A request names an operation, a 16-bit pointer that supplies the memory address, and the byte held in the register operand. The unit reads the addressed byte and combines it with the register byte. It writes the result back to the same address and hands the byte it read to the register file. Four operations exist: swap, bitwise set, bitwise clear and bitwise toggle. None of them produces or changes any condition flag.

The unit drives a synchronous memory port: read data appears one cycle after the read enable. An operation takes two cycles, a read cycle followed by a write cycle. A bus-lock output is held over both cycles so that no other master can reach memory between the read and the write. While an operation is in progress the unit reports busy and ignores new requests. The register file and the instruction decoder sit outside the unit.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After a synchronous active-low reset the unit is idle: `busy`, `bus_lock`, `mem_rd_en`, `mem_wr_en` and `done` are all 0.
- R2: When `req_valid` is 1 on a clock edge while `busy` is 0, the next cycle is the read cycle. In that cycle `mem_rd_en`, `busy` and `bus_lock` are 1 and `mem_addr` equals the captured `req_ptr`.
- R3: The cycle after the read cycle is the write cycle. In it `mem_wr_en`, `done`, `busy` and `bus_lock` are 1 and `mem_addr` is unchanged. The cycle after that is idle again.
- R4: Operation code 0 (swap) writes the register byte to memory.
- R5: Operation code 1 (set) writes the register byte OR the old memory byte.
- R6: Operation code 2 (clear) writes the inverted register byte AND the old memory byte.
- R7: Operation code 3 (toggle) writes the register byte XOR the old memory byte.
- R8: For every operation, `result` in the write cycle equals the memory byte as it was before the operation.
- R9: A request presented while `busy` is 1 is ignored. No further memory access follows the write cycle unless a new request arrives while idle.
- R10: `bus_lock` is 1 in every cycle with a memory access and 0 when idle. Read and write enables are never both 1.
- R11: The operation, pointer and register byte are captured at acceptance. Changes on the request inputs during an operation have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code: 0 swap, 1 set, 2 clear, 3 toggle |
| req_ptr | input | 16 | Pointer value used as the byte address |
| req_reg | input | 8 | Register operand byte |
| busy | output | 1 | Operation in progress; requests are ignored |
| done | output | 1 | Write cycle; `result` is valid |
| result | output | 8 | Old memory byte returned to the register |
| mem_addr | output | 16 | Memory address |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after read enable |
| bus_lock | output | 1 | Holds other masters off the memory |

## Verification
On every cycle the assertions check the control sequence. An accepted request is followed by a read and then by a write at the same address. The lock covers both accesses and is released when idle, the two enables never overlap, and no read follows a write directly. The value of each operation cannot be shown by those properties. The bench scenarios show the data written back by each operation, the returned old byte, and the fact that operands are held at acceptance. They also show that a request during busy leaves memory untouched. A bench memory model and a mirror copy of its contents support these checks.

// File: rtl/rmw_pkg.sv
// Package: shared widths and the operation code type for the atomic
// read-modify-write unit. Assumes byte data and a 16-bit pointer.
package rmw_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        OP_SWAP   = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } rmw_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } rmw_phase_e;
endpackage

// File: rtl/rmw_sequencer.sv
// Module: rmw_sequencer
// Steps idle -> read -> write -> idle. It accepts a request only when idle.
// Assumes the memory returns read data one cycle after the read cycle.
module rmw_sequencer
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic accept,
    output logic rd_phase,
    output logic wr_phase,
    output logic busy
);
    rmw_phase_e phase_q, phase_d;

    // Accept only from idle; requests during an operation are dropped.
    always_comb accept = req_valid && (phase_q == PH_IDLE);

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (accept) phase_d = PH_READ;
            PH_READ:  phase_d = PH_WRITE;
            PH_WRITE: phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Decode phase into strobes.
    always_comb begin
        rd_phase = (phase_q == PH_READ);
        wr_phase = (phase_q == PH_WRITE);
        busy     = (phase_q != PH_IDLE);
    end

    // R2: an accepted request is followed by a read cycle
    a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rd_phase);
    // R3: a read cycle is always followed by a write cycle
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase |=> wr_phase);
    // R9: no read directly follows a write; busy spans the write cycle
    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> !rd_phase);
endmodule

// File: rtl/rmw_operand_hold.sv
// Module: rmw_operand_hold
// Captures the operation, pointer and register byte when a request is
// accepted, and holds them for the whole operation.
module rmw_operand_hold
    import rmw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [1:0]    op_in,
    input  logic [AW-1:0] ptr_in,
    input  logic [DW-1:0] reg_in,
    output rmw_op_e       op_q,
    output logic [AW-1:0] ptr_q,
    output logic [DW-1:0] reg_q
);
    // Operand capture on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= OP_SWAP;
            ptr_q <= '0;
            reg_q <= '0;
        end else if (accept) begin
            op_q  <= rmw_op_e'(op_in);
            ptr_q <= ptr_in;
            reg_q <= reg_in;
        end
    end
endmodule

// File: rtl/rmw_combine.sv
// Module: rmw_combine
// Forms the byte to write back from the register byte and the old memory
// byte. It is purely combinational, and the output is zero outside the
// write cycle.
module rmw_combine
    import rmw_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  rmw_op_e       op,
    input  logic          en,
    input  logic [DW-1:0] reg_b,
    input  logic [DW-1:0] mem_b,
    output logic [DW-1:0] new_b
);
    // Operation select for the write-back value.
    always_comb begin
        new_b = '0;
        if (en) begin
            case (op)
                OP_SWAP:   new_b = reg_b;
                OP_SET:    new_b = reg_b | mem_b;
                OP_CLEAR:  new_b = ~reg_b & mem_b;
                OP_TOGGLE: new_b = reg_b ^ mem_b;
                default:   new_b = reg_b;
            endcase
        end
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
// Module: atomic_rmw_unit (top)
// A two-cycle locked read-modify-write on one memory byte. The first cycle
// reads; the second writes the combined byte and returns the old byte.
// Assumes a synchronous memory with one cycle of read latency.
module atomic_rmw_unit
    import rmw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_ptr,
    input  logic [DW-1:0] req_reg,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_lock
);
    logic          accept, rd_phase, wr_phase, seq_busy;
    rmw_op_e       op_q;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] reg_q;

    rmw_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .accept(accept), .rd_phase(rd_phase), .wr_phase(wr_phase),
        .busy(seq_busy)
    );

    rmw_operand_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .op_in(req_op), .ptr_in(req_ptr), .reg_in(req_reg),
        .op_q(op_q), .ptr_q(ptr_q), .reg_q(reg_q)
    );

    rmw_combine #(.DW(DW)) u_comb (
        .op(op_q), .en(wr_phase), .reg_b(reg_q), .mem_b(mem_rdata),
        .new_b(mem_wdata)
    );

    // Drive the memory port, the lock and the return path.
    always_comb begin
        mem_addr  = ptr_q;
        mem_rd_en = rd_phase;
        mem_wr_en = wr_phase;
        bus_lock  = seq_busy;
        busy      = seq_busy;
        done      = wr_phase;
        result    = wr_phase ? mem_rdata : '0;
    end

    // R10: every memory access is under the lock
    a_r10_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> bus_lock);
    // R10: read and write enables never overlap
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    // R3: write goes to the address that was read
    a_r3_same_address: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && $stable(mem_addr)));
    // R3: lock drops right after the write cycle
    a_r3_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !bus_lock);
endmodule

// File: tb/tb_atomic_rmw_unit.sv
// Directed bench for atomic_rmw_unit, with a synchronous memory model and
// a mirror of its contents.
module tb_atomic_rmw_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_ptr = 16'd0;
    logic [7:0]  req_reg = 8'd0;
    logic        busy, done, mem_rd_en, mem_wr_en, bus_lock;
    logic [7:0]  result, mem_wdata;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem   [0:255];
    logic [7:0] model [0:255];

    always #10 clk = ~clk;

    atomic_rmw_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ptr(req_ptr), .req_reg(req_reg), .busy(busy), .done(done),
        .result(result), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bus_lock(bus_lock)
    );

    // Synchronous memory model with preset contents during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 37 + 5) & 255);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_new(input logic [1:0] op,
                                               input logic [7:0] r,
                                               input logic [7:0] m);
        case (op)
            2'd0: return r;
            2'd1: return r | m;
            2'd2: return ~r & m;
            default: return r ^ m;
        endcase
    endfunction

    // Reset scenario.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 0, "R1 busy", busy, 0);
        chk(bus_lock == 0, "R1 lock", bus_lock, 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R1 enables",
            {mem_rd_en, mem_wr_en}, 0);
        chk(done == 0, "R1 done", done, 0);
    endtask

    // One full operation; the request inputs are scrambled mid-operation (R11).
    task automatic t_op(input logic [1:0] op, input logic [7:0] ptr,
                        input logic [7:0] rv, input string tag);
        logic [7:0] old_b, new_b;
        old_b = model[ptr];
        new_b = expect_new(op, rv, old_b);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_ptr = {8'h00, ptr}; req_reg = rv;
        @(negedge clk);
        req_valid = 1'b0; req_op = ~op; req_ptr = 16'hFFFF; req_reg = ~rv;
        chk(mem_rd_en && busy && bus_lock, "R2 read cycle",
            {mem_rd_en, busy, bus_lock}, 3'b111);
        chk(mem_addr == {8'h00, ptr}, "R2 address", mem_addr, {8'h00, ptr});
        @(negedge clk);
        chk(mem_wr_en && done && bus_lock && !mem_rd_en, "R3 write cycle",
            {mem_wr_en, done, bus_lock, mem_rd_en}, 4'b1110);
        chk(mem_addr == {8'h00, ptr}, "R3 R11 address held", mem_addr,
            {8'h00, ptr});
        chk(mem_wdata == new_b, tag, mem_wdata, new_b);
        chk(result == old_b, "R8 old byte returned", result, old_b);
        model[ptr] = new_b;
        @(negedge clk);
        chk(!busy && !bus_lock && !mem_wr_en, "R3 R10 idle after write",
            {busy, bus_lock, mem_wr_en}, 0);
        chk(mem[ptr] == new_b, "R11 memory content", mem[ptr], new_b);
    endtask

    // Request during busy must be ignored (R9).
    task automatic t_busy_block();
        logic [7:0] other;
        other = model[8'h90];
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_ptr = 16'h0010; req_reg = 8'h0F;
        @(negedge clk);
        req_op = 2'd0; req_ptr = 16'h0090; req_reg = 8'hAA;  // held while busy
        @(negedge clk);
        model[8'h10] = model[8'h10] | 8'h0F;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_rd_en && !busy, "R9 no access after blocked request",
            {mem_rd_en, busy}, 0);
        @(negedge clk);
        chk(!mem_rd_en && !mem_wr_en, "R9 stays idle", {mem_rd_en, mem_wr_en}, 0);
        chk(mem[8'h90] == other, "R9 other byte untouched", mem[8'h90], other);
        chk(mem[8'h10] == model[8'h10], "R9 first op completed", mem[8'h10],
            model[8'h10]);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'((i * 37 + 5) & 255);
        t_reset();
        t_op(2'd0, 8'h05, 8'h3C, "R4 swap write");
        t_op(2'd1, 8'h21, 8'hA0, "R5 set write");
        t_op(2'd2, 8'h42, 8'hF0, "R6 clear write");
        t_op(2'd3, 8'h63, 8'h55, "R7 toggle write");
        t_op(2'd3, 8'h63, 8'hFF, "R7 toggle again");
        t_op(2'd2, 8'h05, 8'h00, "R6 clear none");
        t_op(2'd1, 8'h80, 8'h00, "R5 set none");
        t_op(2'd0, 8'hFF, 8'h00, "R4 swap zero");
        t_busy_block();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule